// File: doc/BRIEF.md
# Multi-Source Reset Sequencer with Cause Flags

This block merges every reset source of a device into a single active-high reset, `dev_rst`, and keeps a small status byte that tells software which kind of reset last happened. The sources are:

- an active-low external reset input, cleaned by a two-stage synchronizer and a consecutive-low glitch filter;
- an asynchronous power-on request;
- a clean digital supply-good indication, used for brown-out detection only while the regulator-enable input is high;
- a one-cycle watchdog request;
- a continuous check that a configuration word equals the bitwise complement of its shadow copy.

After a power-on or a brown-out, a power-up timer holds the reset for a fixed number of clocks once the supply is good. A supply dip during that window returns the block to brown-out, and the timer starts again from zero.

The cause flags are active-low. Hardware clears a flag to 0 when its event occurs. Software can only set a flag back to 1, through a write port. After every reset, software reads the byte to tell a power-on, a brown-out and a configuration upset apart. The external reset input is an input only: no internal reset source drives it.

The sequencer has five states:

- `ST_POR`: power-on, entered asynchronously.
- `ST_BOR`: brown-out hold.
- `ST_PWRT`: power-up timer running.
- `ST_RUN`: normal operation, the only state with `dev_rst` low.
- `ST_SRST`: short reset for the external input, the watchdog or a configuration mismatch.

The transitions are:

- POR→BOR and POR→PWRT when the power-on request ends, to BOR if a brown-out is present and to PWRT otherwise.
- BOR→PWRT when the supply is good.
- PWRT→BOR on a dip.
- PWRT→RUN when the timer expires.
- RUN→BOR on a brown-out.
- RUN→SRST on a short reset source.
- SRST→SRST while a short source stays active.
- SRST→RUN when all short sources are gone.
- SRST→BOR on a brown-out.

A brown-out has priority over every other source.

Top module: `reset_cause_ctrl`

## Requirements
- R1: While `pwr_on_rst` is high, `dev_rst` is 1 without waiting for a clock. After `pwr_on_rst` falls with the supply good, `dev_rst` stays 1 for `PWRT_CYC` clock edges and drops at the next edge.
- R2: A low pulse on `ext_rst_n` lasting fewer than `FILT_CYC` consecutive clocks leaves `dev_rst` at 0.
- R3: When `ext_rst_n` stays low, `dev_rst` rises on the edge `FILT_CYC`+3 after the input fell, which accounts for two synchronizer stages and the filter. `dev_rst` falls on the 4th edge after the input returns high.
- R4: A one-cycle `wdog_req` makes `dev_rst` 1 for exactly the following clock cycle.
- R5: With `regulator_on` high and `supply_ok` low, `dev_rst` is 1 from the next edge and status bit 0 (brown-out flag) reads 0.
- R6: With `regulator_on` low, a low `supply_ok` leaves `dev_rst` and status bit 0 unchanged.
- R7: When `supply_ok` returns high in brown-out, `dev_rst` stays 1 for `PWRT_CYC` edges and falls at the following edge.
- R8: If `supply_ok` falls while the power-up timer runs, `dev_rst` stays 1 and the full `PWRT_CYC` delay is counted again from the next recovery.
- R9: When `cfg_word` is not the bitwise complement of `cfg_shadow`, `dev_rst` is 1 at the next edge and status bit 5 (mismatch flag) reads 0.
- R10: Power-on clears status bits 0 and 1 and leaves bit 5 unchanged. Status bit 1 (power-on flag) is changed by no other reset. Bit 5 is changed only by a mismatch.
- R11: A write with `sw_wr_en` high sets to 1 each of status bits 0, 1 and 5 whose data bit is 1. Data bits at 0 have no effect, a hardware clear in the same cycle wins over the set, and bits 2-4 and 6-7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_on_rst | input | 1 | Power-on request, active high, asynchronous assert |
| ext_rst_n | input | 1 | External reset input, active low, filtered |
| supply_ok | input | 1 | Supply above brown-out threshold |
| regulator_on | input | 1 | Enables brown-out detection |
| wdog_req | input | 1 | Watchdog reset request |
| cfg_word | input | CFG_W | Live configuration word |
| cfg_shadow | input | CFG_W | Complementary shadow of the configuration |
| sw_wr_en | input | 1 | Status write strobe |
| sw_wr_data | input | 8 | Status write data, 1 bits set flags |
| status | output | 8 | Cause flags: bit0 brown-out, bit1 power-on, bit5 mismatch |
| dev_rst | output | 1 | Device reset, active high |

## Verification
The bench aims at the following corner cases. For each, a design that got it wrong would show the symptom described.

- **Glitch filter boundary.** The bench drives pulses one clock short of the filter window and exactly at it, and samples the cycle before and after the expected assertion edge. An off-by-one counter or a missing synchronizer stage would move that edge.
- **Supply dip mid-timer.** A design that resumes the timer instead of restarting it would release reset half a window early.
- **Gated brown-out.** A design that ignores `regulator_on` would reset on a dip while the regulator is off.
- **Flag stickiness.** The bench checks that power-on keeps the mismatch flag, that brown-out keeps the power-on flag, and that a clear and a set arriving together leave the flag at 0. These catch flags wired to the wrong event or with the wrong priority.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
    typedef enum logic [2:0] {
        ST_POR,
        ST_BOR,
        ST_PWRT,
        ST_RUN,
        ST_SRST
    } rst_state_e;

    localparam int STAT_W   = 8;
    localparam int FLAG_BOR = 0;
    localparam int FLAG_PWR = 1;
    localparam int FLAG_CM  = 5;
endpackage

// File: rtl/rcc_pin_filter.sv
module rcc_pin_filter #(
    parameter int FILT_CYC = 8
) (
    input  logic clk,
    input  logic pwr_on_rst,
    input  logic pin_n,
    output logic pin_rst
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(FILT_CYC);

    logic [1:0]    sync_q;
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or posedge pwr_on_rst) begin
        if (pwr_on_rst) begin
            sync_q  <= 2'b11;
            low_cnt <= '0;
        end else begin
            sync_q <= {sync_q[0], pin_n};
            if (sync_q[1]) begin
                low_cnt <= '0;
            end else if (low_cnt != LIMIT) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

    assign pin_rst = (low_cnt == LIMIT);
endmodule

// File: rtl/rcc_pwrup_seq.sv
module rcc_pwrup_seq
    import rcc_pkg::*;
#(
    parameter int PWRT_CYC = 64
) (
    input  logic clk,
    input  logic pwr_on_rst,
    input  logic bor_cond,
    input  logic sync_req,
    output logic dev_rst
);
    localparam int TW = (PWRT_CYC > 2) ? $clog2(PWRT_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(PWRT_CYC - 1);

    rst_state_e    state_q, state_d;
    logic [TW-1:0] tmr_q;

    // state register, power-on asserts asynchronously
    always_ff @(posedge clk or posedge pwr_on_rst) begin
        if (pwr_on_rst) begin
            state_q <= ST_POR;
        end else begin
            state_q <= state_d;
        end
    end

    // power-up timer: counts only while staying in ST_PWRT
    always_ff @(posedge clk or posedge pwr_on_rst) begin
        if (pwr_on_rst) begin
            tmr_q <= '0;
        end else if (state_q == ST_PWRT && state_d == ST_PWRT) begin
            tmr_q <= tmr_q + 1'b1;
        end else begin
            tmr_q <= '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POR:  state_d = bor_cond ? ST_BOR : ST_PWRT;
            ST_BOR:  state_d = bor_cond ? ST_BOR : ST_PWRT;
            ST_PWRT: begin
                if (bor_cond)           state_d = ST_BOR;
                else if (tmr_q == LAST) state_d = ST_RUN;
                else                    state_d = ST_PWRT;
            end
            ST_RUN: begin
                if (bor_cond)      state_d = ST_BOR;
                else if (sync_req) state_d = ST_SRST;
                else               state_d = ST_RUN;
            end
            ST_SRST: begin
                if (bor_cond)      state_d = ST_BOR;
                else if (sync_req) state_d = ST_SRST;
                else               state_d = ST_RUN;
            end
            default: state_d = ST_POR;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  dev_rst = 1'b0;
            default: dev_rst = 1'b1;
        endcase
    end
endmodule

// File: rtl/rcc_status_reg.sv
module rcc_status_reg
    import rcc_pkg::*;
(
    input  logic              clk,
    input  logic              pwr_on_rst,
    input  logic              bor_clr,
    input  logic              cm_clr,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] stat
);
    logic pwr_f, bor_f, cm_f;

    always_ff @(posedge clk or posedge pwr_on_rst) begin
        if (pwr_on_rst) begin
            pwr_f <= 1'b0;
            bor_f <= 1'b0;
        end else begin
            if (wr_en && wr_data[FLAG_PWR]) pwr_f <= 1'b1;
            if (bor_clr)                        bor_f <= 1'b0;
            else if (wr_en && wr_data[FLAG_BOR]) bor_f <= 1'b1;
        end
    end

    // mismatch flag survives power-on: no reset term
    always_ff @(posedge clk) begin
        if (cm_clr)                         cm_f <= 1'b0;
        else if (wr_en && wr_data[FLAG_CM]) cm_f <= 1'b1;
    end

    always_comb begin
        stat           = '0;
        stat[FLAG_BOR] = bor_f;
        stat[FLAG_PWR] = pwr_f;
        stat[FLAG_CM]  = cm_f;
    end
endmodule

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl
    import rcc_pkg::*;
#(
    parameter int CFG_W    = 16,
    parameter int FILT_CYC = 8,
    parameter int PWRT_CYC = 64
) (
    input  logic             clk,
    input  logic             pwr_on_rst,
    input  logic             ext_rst_n,
    input  logic             supply_ok,
    input  logic             regulator_on,
    input  logic             wdog_req,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic [CFG_W-1:0] cfg_shadow,
    input  logic             sw_wr_en,
    input  logic [7:0]       sw_wr_data,
    output logic [7:0]       status,
    output logic             dev_rst
);
    logic             pin_rst;
    logic             bor_cond;
    logic             cfg_bad;
    logic [CFG_W-1:0] bit_bad;

    // each config bit must differ from its shadow bit
    for (genvar i = 0; i < CFG_W; i++) begin : g_cfg_cmp
        assign bit_bad[i] = ~(cfg_word[i] ^ cfg_shadow[i]);
    end
    assign cfg_bad  = |bit_bad;
    assign bor_cond = regulator_on & ~supply_ok;

    rcc_pin_filter #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk        (clk),
        .pwr_on_rst (pwr_on_rst),
        .pin_n      (ext_rst_n),
        .pin_rst    (pin_rst)
    );

    rcc_pwrup_seq #(.PWRT_CYC(PWRT_CYC)) u_seq (
        .clk        (clk),
        .pwr_on_rst (pwr_on_rst),
        .bor_cond   (bor_cond),
        .sync_req   (pin_rst | wdog_req | cfg_bad),
        .dev_rst    (dev_rst)
    );

    rcc_status_reg u_stat (
        .clk        (clk),
        .pwr_on_rst (pwr_on_rst),
        .bor_clr    (bor_cond),
        .cm_clr     (cfg_bad),
        .wr_en      (sw_wr_en),
        .wr_data    (sw_wr_data),
        .stat       (status)
    );
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker #(
    parameter int CFG_W = 16
) (
    input logic             clk,
    input logic             pwr_on_rst,
    input logic             supply_ok,
    input logic             regulator_on,
    input logic             wdog_req,
    input logic [CFG_W-1:0] cfg_word,
    input logic [CFG_W-1:0] cfg_shadow,
    input logic             sw_wr_en,
    input logic [7:0]       sw_wr_data,
    input logic [7:0]       status,
    input logic             dev_rst
);
    // R4: watchdog request resets at the next edge
    p_wdog_rst_r4: assert property (@(posedge clk) disable iff (pwr_on_rst)
        wdog_req |=> dev_rst);

    // R5: brown-out resets and clears the brown-out flag
    p_bor_rst_r5: assert property (@(posedge clk) disable iff (pwr_on_rst)
        (regulator_on && !supply_ok) |=> (dev_rst && !status[0]));

    // R9: configuration mismatch resets and clears its flag
    p_cfg_rst_r9: assert property (@(posedge clk) disable iff (pwr_on_rst)
        (cfg_word != ~cfg_shadow) |=> (dev_rst && !status[5]));

    // R10: power-on flag stays 0 until software sets it
    p_pwr_flag_sticky_r10: assert property (@(posedge clk) disable iff (pwr_on_rst)
        (!status[1] && !(sw_wr_en && sw_wr_data[1])) |=> !status[1]);

    // R11: writing 1 sets the power-on flag
    p_pwr_flag_set_r11: assert property (@(posedge clk) disable iff (pwr_on_rst)
        (sw_wr_en && sw_wr_data[1]) |=> status[1]);

    // R11: unused status bits read 0
    p_unused_zero_r11: assert property (@(posedge clk) disable iff (pwr_on_rst)
        (status & 8'hDC) == 8'h00);
endmodule

bind reset_cause_ctrl rcc_checker #(.CFG_W(CFG_W)) i_rcc_checker (
    .clk          (clk),
    .pwr_on_rst   (pwr_on_rst),
    .supply_ok    (supply_ok),
    .regulator_on (regulator_on),
    .wdog_req     (wdog_req),
    .cfg_word     (cfg_word),
    .cfg_shadow   (cfg_shadow),
    .sw_wr_en     (sw_wr_en),
    .sw_wr_data   (sw_wr_data),
    .status       (status),
    .dev_rst      (dev_rst)
);

// File: tb/test_reset_cause_ctrl.sv
module test_reset_cause_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CFG_W      = 16;
    localparam int FILT_CYC   = 8;
    localparam int PWRT_CYC   = 64;
    localparam logic [CFG_W-1:0] CFG_VAL = 16'hA5C3;

    logic             clk = 1'b0;
    logic             pwr_on_rst = 1'b1;
    logic             ext_rst_n = 1'b1;
    logic             supply_ok = 1'b1;
    logic             regulator_on = 1'b1;
    logic             wdog_req = 1'b0;
    logic [CFG_W-1:0] cfg_word = CFG_VAL;
    logic [CFG_W-1:0] cfg_shadow = ~CFG_VAL;
    logic             sw_wr_en = 1'b0;
    logic [7:0]       sw_wr_data = 8'h00;
    logic [7:0]       status;
    logic             dev_rst;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    reset_cause_ctrl #(.CFG_W(CFG_W), .FILT_CYC(FILT_CYC), .PWRT_CYC(PWRT_CYC)) i_reset_cause_ctrl (
        .clk          (clk),
        .pwr_on_rst   (pwr_on_rst),
        .ext_rst_n    (ext_rst_n),
        .supply_ok    (supply_ok),
        .regulator_on (regulator_on),
        .wdog_req     (wdog_req),
        .cfg_word     (cfg_word),
        .cfg_shadow   (cfg_shadow),
        .sw_wr_en     (sw_wr_en),
        .sw_wr_data   (sw_wr_data),
        .status       (status),
        .dev_rst      (dev_rst)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic sw_write(input logic [7:0] d);
        sw_wr_en   = 1'b1;
        sw_wr_data = d;
        tick(1);
        sw_wr_en   = 1'b0;
        sw_wr_data = 8'h00;
    endtask

    task automatic t_power_on;
        tick(3);
        check("R1 reset during power-on", {7'd0, dev_rst}, 8'h01);
        check("R10 power-on clears bits 0,1", status & 8'h03, 8'h00);
        pwr_on_rst = 1'b0;
        tick(PWRT_CYC);
        check("R1 held through timer", {7'd0, dev_rst}, 8'h01);
        tick(1);
        check("R1 released after timer", {7'd0, dev_rst}, 8'h00);
    endtask

    task automatic t_sw_write;
        sw_write(8'h00);
        check("R11 zero write no effect", status & 8'h03, 8'h00);
        sw_write(8'hFF);
        check("R11 ones set flags only", status, 8'h23);
    endtask

    task automatic t_short_glitch;
        ext_rst_n = 1'b0;
        tick(FILT_CYC - 1);
        ext_rst_n = 1'b1;
        for (int i = 0; i < FILT_CYC + 6; i++) begin
            check("R2 short pulse ignored", {7'd0, dev_rst}, 8'h00);
            tick(1);
        end
    endtask

    task automatic t_pin_reset;
        ext_rst_n = 1'b0;
        tick(FILT_CYC + 2);
        check("R3 not yet asserted", {7'd0, dev_rst}, 8'h00);
        tick(1);
        check("R3 asserted after filter", {7'd0, dev_rst}, 8'h01);
        tick(5);
        ext_rst_n = 1'b1;
        tick(3);
        check("R3 still held after release", {7'd0, dev_rst}, 8'h01);
        tick(1);
        check("R3 released", {7'd0, dev_rst}, 8'h00);
        check("R10 pin reset keeps flags", status, 8'h23);
    endtask

    task automatic t_watchdog;
        wdog_req = 1'b1;
        tick(1);
        wdog_req = 1'b0;
        check("R4 watchdog reset", {7'd0, dev_rst}, 8'h01);
        tick(1);
        check("R4 one cycle only", {7'd0, dev_rst}, 8'h00);
        check("R10 watchdog keeps flags", status, 8'h23);
    endtask

    task automatic t_bor_gated;
        regulator_on = 1'b0;
        supply_ok    = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tick(1);
            check("R6 gated brown-out no reset", {7'd0, dev_rst}, 8'h00);
        end
        check("R6 gated brown-out flag kept", status, 8'h23);
        supply_ok    = 1'b1;
        tick(1);
        regulator_on = 1'b1;
        tick(1);
    endtask

    task automatic t_bor;
        supply_ok = 1'b0;
        tick(1);
        check("R5 brown-out reset", {7'd0, dev_rst}, 8'h01);
        check("R5 brown-out flag cleared", status, 8'h22);
        tick(3);
        supply_ok = 1'b1;
        tick(PWRT_CYC);
        check("R7 held through timer", {7'd0, dev_rst}, 8'h01);
        tick(1);
        check("R7 released after timer", {7'd0, dev_rst}, 8'h00);
        check("R10 brown-out keeps power-on flag", status, 8'h22);
        sw_write(8'h01);
        check("R11 set brown-out flag", status, 8'h23);
    endtask

    task automatic t_dip;
        supply_ok = 1'b0;
        tick(2);
        supply_ok = 1'b1;
        tick(PWRT_CYC / 2);
        supply_ok = 1'b0;
        tick(1);
        check("R8 dip re-enters brown-out", {7'd0, dev_rst}, 8'h01);
        tick(2);
        supply_ok = 1'b1;
        tick(PWRT_CYC);
        check("R8 timer restarted", {7'd0, dev_rst}, 8'h01);
        tick(1);
        check("R8 released after full delay", {7'd0, dev_rst}, 8'h00);
        sw_write(8'h01);
    endtask

    task automatic t_cfg_mismatch;
        cfg_shadow = ~CFG_VAL ^ 16'h0008;
        tick(1);
        check("R9 mismatch reset", {7'd0, dev_rst}, 8'h01);
        check("R9 mismatch flag cleared", status, 8'h03);
        cfg_shadow = ~CFG_VAL;
        tick(1);
        check("R9 released after mismatch", {7'd0, dev_rst}, 8'h00);
        cfg_word   = CFG_VAL ^ 16'h8000;
        sw_wr_en   = 1'b1;
        sw_wr_data = 8'h20;
        tick(1);
        sw_wr_en   = 1'b0;
        sw_wr_data = 8'h00;
        cfg_word   = CFG_VAL;
        check("R11 clear wins over set", status, 8'h03);
        tick(2);
    endtask

    task automatic t_power_on_keeps_cm;
        pwr_on_rst = 1'b1;
        tick(2);
        check("R10 power-on keeps mismatch flag 0", status, 8'h00);
        pwr_on_rst = 1'b0;
        tick(PWRT_CYC + 1);
        sw_write(8'h20);
        check("R11 set mismatch flag", status, 8'h20);
        pwr_on_rst = 1'b1;
        tick(2);
        check("R10 power-on keeps mismatch flag 1", status, 8'h20);
        pwr_on_rst = 1'b0;
        tick(PWRT_CYC + 1);
        check("R1 released after second power-on", {7'd0, dev_rst}, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_power_on();
        t_sw_write();
        t_short_glitch();
        t_pin_reset();
        t_watchdog();
        t_bor_gated();
        t_bor();
        t_dip();
        t_cfg_mismatch();
        t_power_on_keeps_cm();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule